// File: doc/BRIEF.md
# Selectable-Length Feedback Averaging Filter

This block smooths a stream of signed encoder samples (position or velocity) with a moving-average filter whose taps are all equal. A 3-bit length code, which may change at run time, picks the window length from a ladder that doubles from 1 up to 64 and then stops at 127 rather than 128. Each accepted sample enters a circular delay line. A running sum adds the newest sample and subtracts the one that leaves the window. The sum is then scaled to a mean: an arithmetic shift for the power-of-two lengths, and a multiply by a fixed-point reciprocal for the 127-tap length.

A direction input reverses the counting sense. When it is high, each sample is negated as it is accepted. Changing the length code, or raising the synchronous software reset, empties the window. The output stays invalid until the new window has filled again, so a partly filled window never produces a mean. The result is a 32-bit signed word with a valid strobe, two clocks after the sample that produced it.

Top module: `fbk_avg_filter`

## Requirements
- R1: The length code selects the window length N: code 0→1, 1→2, 2→4, 3→8, 4→16, 5→32, 6→64, 7→127. Once the window is full, each output is derived from the sum of the last N accepted samples.
- R2: With code 0, every accepted sample produces an output equal to that sample, sign-extended to 32 bits.
- R3: For codes 0 to 6, the output is the window sum shifted right arithmetically by the code value, which is floor(sum/N), rounding toward minus infinity.
- R4: For code 7, the output is the window sum divided by 127 and truncated toward zero, exact over the whole input range.
- R5: When `reverse` is 1 in the cycle a sample is accepted, that sample enters the window negated. The setting applies to each sample on its own.
- R6: `out_valid` rises exactly 2 clock edges after the edge that accepts the sample producing it. Every `out_valid` pulse follows an accepted sample.
- R7: After reset, a software reset or a change of length code, `out_valid` stays low until N samples have been accepted. The Nth sample produces the first output.
- R8: In a cycle where `soft_rst` is high or `len_code` differs from its previous value, the sample on the input is discarded and the result still in flight is suppressed. `out_valid` is low in the two cycles that follow.
- R9: `out_data` changes only in cycles where `out_valid` is high, and it holds its value between outputs.
- R10: While `rst` is high, `out_valid` and `out_data` are driven to 0.
- R11: A full window of 127 samples of the most negative input value, in either direction, produces the exact mean with no accumulator overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | IN_W (24) | Signed input sample |
| len_code | input | 3 | Window length select |
| reverse | input | 1 | 1 = negate samples (count down) |
| soft_rst | input | 1 | Synchronous window clear |
| out_valid | output | 1 | Output strobe |
| out_data | output | OUT_W (32) | Signed filtered value |

## Verification
A wrong fill count or a wrong delay-line read address shows up at the first output of each window as a value that differs from the bench's mean of the last N samples. Such a fault can also appear as an output pulse that comes one sample early or late, and it is seen within one window length of the fault. A running sum that is not cleared, or that subtracts a stale entry, leaves a constant offset on every following output. The 127-tap test, whose first window sums to -1 and must give 0 rather than -1, exposes a reciprocal that rounds toward minus infinity instead of toward zero. The clear and code-change tests send a sample in the clear cycle and one sample just before it. Any leak of either sample appears within two clocks as an output pulse that no sample explains.

// File: rtl/fbk_avg_pkg.sv
package fbk_avg_pkg;
  localparam int CODE_W = 3;

  // Window length for a code: powers of two, with the top code mapped to long_len
  function automatic int taps_of(input logic [CODE_W-1:0] c, input int long_len);
    if (c == '1) return long_len;
    return 1 << c;
  endfunction
endpackage

// File: rtl/fbk_delay_ram.sv
module fbk_delay_ram #(
  parameter int W  = 25,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // Simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fbk_avg_window.sv
module fbk_avg_window #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  input  logic [LEN_W-1:0] taps,
  output logic             drop,
  output logic             ready
);
  logic [LEN_W-1:0] fill;
  logic             full_now;

  assign full_now = (fill == taps);
  assign drop     = full_now;
  assign ready    = full_now || ((fill + LEN_W'(1)) == taps);

  always_ff @(posedge clk) begin
    if (rst || clear)
      fill <= '0;
    else if (advance && !full_now)
      fill <= fill + LEN_W'(1);
  end
endmodule

// File: rtl/fbk_avg_scale.sv
module fbk_avg_scale #(
  parameter int ACC_W     = 32,
  parameter int OUT_W     = 32,
  parameter int CODE_W    = 3,
  parameter int LONG_TAPS = 127
) (
  input  logic signed [ACC_W-1:0] sum,
  input  logic [CODE_W-1:0]       code,
  output logic signed [OUT_W-1:0] result
);
  localparam int LT_W = $clog2(LONG_TAPS + 1);
  localparam int KS   = ACC_W + LT_W;
  localparam int KP1  = KS + 1;
  localparam int PW   = ACC_W + KP1;
  localparam logic [KP1-1:0] ONE_K = KP1'(1) << KS;
  localparam logic [KP1-1:0] RECIP = (ONE_K + KP1'(LONG_TAPS - 1)) / KP1'(LONG_TAPS);

  logic [ACC_W-1:0]        mag;
  logic [PW-1:0]           prod;
  logic [ACC_W-1:0]        qmag;
  logic signed [ACC_W-1:0] qdiv;
  logic signed [ACC_W-1:0] qshift;
  logic signed [ACC_W-1:0] qsel;

  always_comb begin
    mag    = sum[ACC_W-1] ? ACC_W'(-sum) : ACC_W'(sum);
    prod   = PW'(mag) * PW'(RECIP);
    qmag   = ACC_W'(prod >> KS);
    qdiv   = sum[ACC_W-1] ? -$signed(qmag) : $signed(qmag);
    qshift = sum >>> code;
    qsel   = (code == '1) ? qdiv : qshift;
    result = OUT_W'(qsel);
  end
endmodule

// File: rtl/fbk_avg_filter.sv
module fbk_avg_filter
  import fbk_avg_pkg::*;
#(
  parameter int IN_W      = 24,
  parameter int OUT_W     = 32,
  parameter int LONG_TAPS = 127
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  input  logic [CODE_W-1:0]       len_code,
  input  logic                    reverse,
  input  logic                    soft_rst,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int LEN_W = $clog2(LONG_TAPS + 1);
  localparam int AW    = LEN_W;
  localparam int SW    = IN_W + 1;
  localparam int ACC_W = SW + LEN_W;

  logic [CODE_W-1:0]       code_q;
  logic                    clear;
  logic                    accept;
  logic [LEN_W-1:0]        taps;
  logic [AW-1:0]           wp;
  logic [AW-1:0]           raddr;
  logic signed [SW-1:0]    s_in;
  logic [SW-1:0]           old_raw;
  logic                    drop, ready;

  logic                    v1, drop1, ready1;
  logic signed [SW-1:0]    s1;
  logic [CODE_W-1:0]       code1;

  logic signed [ACC_W-1:0] sum, sum_nx;
  logic signed [OUT_W-1:0] scaled;

  assign clear  = soft_rst || (len_code != code_q);
  assign accept = in_valid && !clear;
  assign taps   = LEN_W'(taps_of(len_code, LONG_TAPS));
  assign s_in   = reverse ? -SW'(in_data) : SW'(in_data);
  assign raddr  = wp - AW'(taps);

  always_ff @(posedge clk) code_q <= len_code;

  always_ff @(posedge clk) begin
    if (rst || clear) wp <= '0;
    else if (accept)  wp <= wp + AW'(1);
  end

  fbk_delay_ram #(.W(SW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (accept),
    .waddr (wp),
    .wdata (s_in),
    .re    (accept),
    .raddr (raddr),
    .rdata (old_raw)
  );

  fbk_avg_window #(.LEN_W(LEN_W)) u_win (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .advance (accept),
    .taps    (taps),
    .drop    (drop),
    .ready   (ready)
  );

  // Stage 1: sample registered alongside the delay-line read
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      v1     <= 1'b0;
      drop1  <= 1'b0;
      ready1 <= 1'b0;
    end else begin
      v1     <= accept;
      drop1  <= drop;
      ready1 <= ready;
    end
    s1    <= s_in;
    code1 <= len_code;
  end

  assign sum_nx = sum + ACC_W'(s1) - (drop1 ? ACC_W'($signed(old_raw)) : '0);

  fbk_avg_scale #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .CODE_W(CODE_W), .LONG_TAPS(LONG_TAPS)
  ) u_scale (
    .sum    (sum_nx),
    .code   (code1),
    .result (scaled)
  );

  // Stage 2: running sum and registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      sum       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (clear) begin
      sum       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= v1 && ready1;
      if (v1) sum <= sum_nx;
      if (v1 && ready1) out_data <= scaled;
    end
  end
endmodule

// File: rtl/fbk_avg_filter_chk.sv
module fbk_avg_filter_chk #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic signed [IN_W-1:0]  in_data,
  input logic [2:0]              len_code,
  input logic                    reverse,
  input logic                    soft_rst,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_data
);
  // R6: each output pulse traces back to a sample two edges earlier
  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  // R8: software reset silences the output for the next two cycles
  assert_softrst_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !out_valid);
  assert_softrst_quiet2_R8: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> ##2 !out_valid);

  // R7: a length change empties the window, so no output follows at once
  assert_code_change_R7: assert property (@(posedge clk) disable iff (rst)
    (len_code != $past(len_code)) |=> !out_valid);

  // R2: single-tap window passes the sample straight through
  assert_passthru_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(len_code, 2) == 3'd0 && !$past(reverse, 2))
      |-> out_data == OUT_W'($past(in_data, 2)));

  // R5: single-tap window with reverse set returns the negated sample
  assert_negate_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(len_code, 2) == 3'd0 && $past(reverse, 2))
      |-> out_data == -OUT_W'($past(in_data, 2)));

  // R9: the output word moves only together with the strobe
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_data) |-> out_valid);
endmodule

bind fbk_avg_filter fbk_avg_filter_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/fbk_avg_filter_test.sv
module fbk_avg_filter_test;
  localparam int IN_W  = 24;
  localparam int OUT_W = 32;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    in_valid = 1'b0;
  logic signed [IN_W-1:0]  in_data = '0;
  logic [2:0]              len_code = 3'd0;
  logic                    reverse = 1'b0;
  logic                    soft_rst = 1'b0;
  logic                    out_valid;
  logic signed [OUT_W-1:0] out_data;

  always #10 clk = ~clk;

  fbk_avg_filter #(.IN_W(IN_W), .OUT_W(OUT_W)) uut (.*);

  int     n_tests = 0;
  int     n_fail  = 0;
  longint win[$];
  longint exp_v[$];
  string  exp_tag[$];
  int     ntaps = 1;
  int     cur_code = 0;
  string  cur_tag = "R2";
  bit     last_pushed = 0;
  int     seed = 7;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic int taps_for(input int c);
    return (c == 7) ? 127 : (1 << c);
  endfunction

  // Driver: one sample, model updated, expected item queued when the window is full
  task automatic send(input int x);
    longint v, s;
    in_valid = 1'b1;
    in_data  = IN_W'(x);
    v = reverse ? -longint'(x) : longint'(x);
    win.push_back(v);
    if (win.size() > ntaps) void'(win.pop_front());
    last_pushed = 0;
    if (win.size() == ntaps) begin
      s = 0;
      foreach (win[i]) s += win[i];
      exp_v.push_back((cur_code == 7) ? s / 127 : s >>> cur_code);
      exp_tag.push_back(cur_tag);
      last_pushed = 1;
    end
    tick();
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    last_pushed = 0;
    repeat (n) tick();
  endtask

  // Code change cycle: the in-flight result is suppressed (R8)
  task automatic set_code(input int c);
    if (last_pushed) begin
      void'(exp_v.pop_back());
      void'(exp_tag.pop_back());
    end
    last_pushed = 0;
    len_code = 3'(c);
    cur_code = c;
    ntaps = taps_for(c);
    win.delete();
    tick();
  endtask

  function automatic int lcg();
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) % 400000);
  endfunction

  // Monitor: pop and compare each produced result
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_v.size() == 0) begin
        check(1'b0, "R7 unexpected output", longint'(out_data), 0);
      end else begin
        longint e;
        string  t;
        e = exp_v.pop_front();
        t = exp_tag.pop_front();
        check(longint'(out_data) == e, t, longint'(out_data), e);
      end
    end
  end

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL R6 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    longint held;
    repeat (3) tick();
    @(negedge clk);
    // R10 reset state
    check(out_valid == 1'b0, "R10 valid in reset", out_valid, 0);
    check(out_data == 0, "R10 data in reset", longint'(out_data), 0);
    tick();
    rst = 1'b0;
    idle(2);

    // R6 latency, code 0
    cur_tag = "R6";
    send(1234);
    @(negedge clk);
    check(out_valid == 1'b0, "R6 valid after one edge", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R6 valid after two edges", out_valid, 1);
    check(out_data == 1234, "R6 data", longint'(out_data), 1234);
    idle(2);

    // R2 pass-through
    cur_tag = "R2";
    send(-5); send(77); idle(1); send(-8388608); send(8388607); send(0);
    idle(3);

    // R3 / R7: four taps, floor rounding of a negative sum
    set_code(2);
    cur_tag = "R3";
    send(5); send(-2); send(-7);
    idle(1);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 no output before window full", out_valid, 0);
    tick();
    send(1);          // sum -3 -> -1
    idle(1);
    for (int i = 0; i < 10; i++) send(lcg());
    idle(3);

    // R1: eight taps with gaps
    set_code(3);
    cur_tag = "R1";
    for (int i = 0; i < 20; i++) begin
      send(i * 1000 - 7003);
      if (i % 3 == 0) idle(1);
    end
    idle(3);

    // R5: reverse toggled per sample
    cur_tag = "R5";
    for (int i = 0; i < 16; i++) begin
      reverse = i[0];
      send(lcg());
    end
    reverse = 1'b0;
    idle(3);

    // R4: 127 taps, sum -1 must give 0 (toward zero)
    set_code(7);
    cur_tag = "R4";
    send(-1);
    for (int i = 0; i < 126; i++) send(0);
    for (int i = 0; i < 40; i++) send(lcg());
    idle(3);

    // R11: full-scale negative input in both directions
    set_code(6); set_code(7);
    cur_tag = "R11";
    reverse = 1'b1;
    for (int i = 0; i < 127; i++) send(-8388608);
    reverse = 1'b0;
    for (int i = 0; i < 127; i++) send(-8388608);
    idle(3);

    // R9: output holds while idle
    @(negedge clk);
    held = longint'(out_data);
    idle(5);
    @(negedge clk);
    check(longint'(out_data) == held && !out_valid, "R9 hold", longint'(out_data), held);
    tick();

    // R8: soft reset with a sample in flight and one in the clear cycle
    set_code(0);
    cur_tag = "R8";
    send(11); send(22);
    soft_rst = 1'b1;
    in_valid = 1'b1;
    in_data  = IN_W'(999);
    if (last_pushed) begin
      void'(exp_v.pop_back());
      void'(exp_tag.pop_back());
    end
    win.delete();
    tick();
    soft_rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 quiet cycle 1", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 quiet cycle 2", out_valid, 0);
    tick();
    send(-44);
    idle(3);

    // R7: code change mid-stream, first output after two new samples
    send(5);
    set_code(1);
    cur_tag = "R7";
    send(100);
    idle(1);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 window of two not full", out_valid, 0);
    tick();
    send(-301);       // sum -201 -> -101
    idle(4);

    check(exp_v.size() == 0, "R6 all expected outputs seen", exp_v.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule